// File: doc/BRIEF.md
# TLB Duplicate Entry Scrubber

This block walks the main translation buffer after an overlap fault and removes entries that duplicate one another. For each set it reads every way into a local copy, one read per cycle. It then checks whether any of those entries has its valid bit set. A set with no valid entry is passed over without any comparison.

In a set that holds at least one valid entry, the block compares the page-number fields of every pair of ways (i, j) with i < j. The page-number field is the descriptor with its in-page offset bits masked off. When a pair matches, the lower way i is erased in storage, which clears both descriptor words of that entry, and in the local copy. Way j is kept. A way whose descriptor is all zero is never used as the first member of a pair, so a way that has just been erased cannot cause another erase in the same set.

The walk starts on a one-cycle start pulse. It ends with a one-cycle done pulse. The done pulse comes with a saturating count of the erased entries and with the set and way of the most recent erase. The storage is reached through a plain port that takes a linear index. Reads return data one cycle after the request. A clear takes effect at the clock edge that ends the clear cycle.

Top module: `tlb_dup_scrubber`

## Requirements
- R1: After reset, and until the first start pulse, `mem_rd_o`, `mem_clr_o` and `done_o` are low and `dup_cnt_o` is 0.
- R2: A start pulse in the idle state visits sets 0 to SETS-1 in increasing order. Within each set it reads ways 0 to WAYS-1 on consecutive cycles at linear index set*WAYS+way, so one scan reads every index from 0 to SETS*WAYS-1 exactly once and in order.
- R3: A set in which no entry has bit VLD_BIT (default 10) set produces no clear, even when its page-number fields are equal.
- R4: When ways i < j of a set have equal bits [PD_W-1:OFF_W] (default [31:13]) and way i is not all zero, the block issues one clear at index set*WAYS+i. Way j is left intact and is never cleared for that match.
- R5: An erased way is zero in the local copy, so it starts no further match. Four equal valid ways lose ways 0, 1 and 2. An all-zero way 0 followed by three equal ways loses ways 1 and 2.
- R6: Bits below OFF_W take no part in the comparison. Two entries that differ only there match, and two entries that differ in a single page-number bit do not.
- R7: A single one-cycle `done_o` pulse follows the last set. At that time `dup_cnt_o` holds the number of clears issued in this scan, saturated at 2^CNT_W-1 (default 15).
- R8: At `done_o`, `last_set_o` and `last_way_o` give the set and way of the last clear of the scan. They are 0 when the scan found no duplicate.
- R9: A start pulse that arrives during a scan is ignored. The scan neither restarts nor produces a second done pulse.
- R10: A read and a clear never occur in the same cycle, and every access index is below SETS*WAYS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that starts a scan while idle |
| mem_rd_o | output | 1 | Read request at `mem_addr_o`; data is returned on the next cycle |
| mem_clr_o | output | 1 | Clears both descriptor words of the entry at `mem_addr_o` |
| mem_addr_o | output | $clog2(SETS*WAYS) | Linear entry index, set*WAYS+way |
| mem_rdata_i | input | PD_W | First descriptor word of the entry read on the previous cycle |
| done_o | output | 1 | One-cycle pulse at the end of the scan |
| dup_cnt_o | output | CNT_W | Saturating count of entries erased in this scan |
| last_set_o | output | $clog2(SETS) | Set of the most recent erase |
| last_way_o | output | $clog2(WAYS) | Way of the most recent erase |

## Verification
The embedded assertions check the following on every cycle: reads and clears never overlap and always stay in range, reads inside a set advance by one index per cycle, a clear never targets the highest way, an erased local copy reads zero on the next cycle, the counter holds at its maximum, and the done pulse lasts one cycle. The bench scenarios cover what a single-cycle property cannot see. These are the choice of which ways are cleared in a set, the skipping of sets with no valid entry, the masking of offset bits, the cascade in which an erased way stops matching, the saturated count, the last-erase location, and a start pulse that arrives during a scan. Each of these is checked against a reference model over the final storage contents and the ordered list of clears.

// File: rtl/tlbs_pkg.sv
package tlbs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_SETTLE,
      ST_VCHK,
      ST_PAIR,
      ST_CLEAR,
      ST_NEXT
   } scrub_state_t;

endpackage

// File: rtl/tlbs_way_buf.sv
module tlbs_way_buf #(
   parameter int WAYS    = 4,
   parameter int PD_W    = 32,
   parameter int VLD_BIT = 10,
   localparam int WW     = $clog2(WAYS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en_i,
   input  logic [WW-1:0]              wr_idx_i,
   input  logic [PD_W-1:0]            wr_data_i,
   input  logic                       clr_en_i,
   input  logic [WW-1:0]              clr_idx_i,
   output logic [WAYS-1:0][PD_W-1:0]  loc_o,
   output logic                       any_vld_o
);

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      logic [PD_W-1:0] loc_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            loc_q <= '0;
         end else if (clr_en_i && clr_idx_i == WW'(g)) begin
            loc_q <= '0;
         end else if (wr_en_i && wr_idx_i == WW'(g)) begin
            loc_q <= wr_data_i;
         end
      end

      assign loc_o[g] = loc_q;

      // R5: an erased local copy no longer holds a page that could match
      assert_local_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_en_i && clr_idx_i == WW'(g)) |=> (loc_q == '0));
   end

   always_comb begin
      any_vld_o = 1'b0;
      for (int k = 0; k < WAYS; k++) begin
         any_vld_o = any_vld_o | loc_o[k][VLD_BIT];
      end
   end

endmodule

// File: rtl/tlbs_pair_cmp.sv
module tlbs_pair_cmp #(
   parameter int WAYS  = 4,
   parameter int PD_W  = 32,
   parameter int OFF_W = 13,
   localparam int WW   = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][PD_W-1:0]  loc_i,
   input  logic [WW-1:0]              lo_i,
   input  logic [WW-1:0]              hi_i,
   output logic                       lo_zero_o,
   output logic                       match_o
);

   logic [PD_W-1:0] lo_pd;
   logic [PD_W-1:0] hi_pd;

   assign lo_pd     = loc_i[lo_i];
   assign hi_pd     = loc_i[hi_i];
   assign lo_zero_o = (lo_pd == '0);
   assign match_o   = !lo_zero_o && (lo_pd[PD_W-1:OFF_W] == hi_pd[PD_W-1:OFF_W]);

endmodule

// File: rtl/tlbs_sat_cnt.sv
module tlbs_sat_cnt #(
   parameter int CNT_W = 4,
   localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         cnt_o <= '0;
      end else if (inc_i && cnt_o != CNT_MAX) begin
         cnt_o <= cnt_o + CNT_W'(1);
      end
   end

   // R7: the count holds at its ceiling instead of wrapping
   assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == CNT_MAX && !clr_i) |=> (cnt_o == CNT_MAX));

endmodule

// File: rtl/tlb_dup_scrubber.sv
module tlb_dup_scrubber
   import tlbs_pkg::*;
#(
   parameter int SETS    = 8,
   parameter int WAYS    = 4,
   parameter int PD_W    = 32,
   parameter int OFF_W   = 13,
   parameter int VLD_BIT = 10,
   parameter int CNT_W   = 4,
   localparam int SW     = $clog2(SETS),
   localparam int WW     = $clog2(WAYS),
   localparam int NENT   = SETS * WAYS,
   localparam int AW     = $clog2(NENT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             mem_rd_o,
   output logic             mem_clr_o,
   output logic [AW-1:0]    mem_addr_o,
   input  logic [PD_W-1:0]  mem_rdata_i,
   output logic             done_o,
   output logic [CNT_W-1:0] dup_cnt_o,
   output logic [SW-1:0]    last_set_o,
   output logic [WW-1:0]    last_way_o
);

   if (SETS < 2)                      begin : g_bad_sets  $error("SETS must be at least 2");   end
   if (WAYS < 2)                      begin : g_bad_ways  $error("WAYS must be at least 2");   end
   if (OFF_W < 1 || OFF_W >= PD_W)    begin : g_bad_off   $error("OFF_W out of range");        end
   if (VLD_BIT < 0 || VLD_BIT >= PD_W) begin : g_bad_vld  $error("VLD_BIT out of range");      end
   if (CNT_W < 1)                     begin : g_bad_cnt   $error("CNT_W must be positive");    end

   scrub_state_t state_q;
   logic [SW-1:0] set_q;
   logic [WW-1:0] rw_q, pi_q, pj_q, clr_way_q, pend_way_q, sel_way;
   logic          pend_q, end_q, done_q;
   logic [SW-1:0] last_set_q;
   logic [WW-1:0] last_way_q;

   logic [WAYS-1:0][PD_W-1:0] loc;
   logic any_vld, lo_zero, match;
   logic pj_last, pi_last, adv_i, pair_set_end, hit;

   tlbs_way_buf #(.WAYS(WAYS), .PD_W(PD_W), .VLD_BIT(VLD_BIT)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (pend_q),
      .wr_idx_i  (pend_way_q),
      .wr_data_i (mem_rdata_i),
      .clr_en_i  (hit),
      .clr_idx_i (pi_q),
      .loc_o     (loc),
      .any_vld_o (any_vld)
   );

   tlbs_pair_cmp #(.WAYS(WAYS), .PD_W(PD_W), .OFF_W(OFF_W)) u_cmp (
      .loc_i     (loc),
      .lo_i      (pi_q),
      .hi_i      (pj_q),
      .lo_zero_o (lo_zero),
      .match_o   (match)
   );

   tlbs_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (state_q == ST_IDLE && start_i),
      .inc_i (hit),
      .cnt_o (dup_cnt_o)
   );

   assign hit          = (state_q == ST_PAIR) && match;
   assign pj_last      = (pj_q == WW'(WAYS - 1));
   assign pi_last      = (pi_q == WW'(WAYS - 2));
   assign adv_i        = match || lo_zero || pj_last;
   assign pair_set_end = adv_i && pi_last;

   assign mem_rd_o  = (state_q == ST_READ);
   assign mem_clr_o = (state_q == ST_CLEAR);
   assign sel_way   = (state_q == ST_CLEAR) ? clr_way_q : rw_q;

   if ((1 << WW) == WAYS) begin : g_addr_cat
      assign mem_addr_o = AW'({set_q, sel_way});
   end else begin : g_addr_mul
      assign mem_addr_o = AW'(set_q) * AW'(WAYS) + AW'(sel_way);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         set_q      <= '0;
         rw_q       <= '0;
         pi_q       <= '0;
         pj_q       <= '0;
         clr_way_q  <= '0;
         pend_q     <= 1'b0;
         pend_way_q <= '0;
         end_q      <= 1'b0;
         done_q     <= 1'b0;
         last_set_q <= '0;
         last_way_q <= '0;
      end else begin
         done_q     <= 1'b0;
         pend_q     <= (state_q == ST_READ);
         pend_way_q <= rw_q;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  set_q      <= '0;
                  rw_q       <= '0;
                  last_set_q <= '0;
                  last_way_q <= '0;
                  state_q    <= ST_READ;
               end
            end
            ST_READ: begin
               if (rw_q == WW'(WAYS - 1)) begin
                  rw_q    <= '0;
                  state_q <= ST_SETTLE;
               end else begin
                  rw_q <= rw_q + WW'(1);
               end
            end
            ST_SETTLE: state_q <= ST_VCHK;
            ST_VCHK: begin
               pi_q    <= '0;
               pj_q    <= WW'(1);
               state_q <= any_vld ? ST_PAIR : ST_NEXT;
            end
            ST_PAIR: begin
               if (adv_i) begin
                  pi_q <= pi_q + WW'(1);
                  pj_q <= pi_q + WW'(2);
               end else begin
                  pj_q <= pj_q + WW'(1);
               end
               if (match) begin
                  clr_way_q  <= pi_q;
                  end_q      <= pair_set_end;
                  last_set_q <= set_q;
                  last_way_q <= pi_q;
                  state_q    <= ST_CLEAR;
               end else if (pair_set_end) begin
                  state_q <= ST_NEXT;
               end
            end
            ST_CLEAR: state_q <= end_q ? ST_NEXT : ST_PAIR;
            ST_NEXT: begin
               if (set_q == SW'(SETS - 1)) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  set_q   <= set_q + SW'(1);
                  state_q <= ST_READ;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done_o     = done_q;
   assign last_set_o = last_set_q;
   assign last_way_o = last_way_q;

   // R10: one storage access per cycle, always inside the array
   assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_clr_o));
   assert_addr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o || mem_clr_o) |-> (int'(mem_addr_o) < NENT));
   // R2: back-to-back reads walk the ways of one set in order
   assert_read_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(1)));
   // R4: the kept member of a pair is the higher way, so the top way is never erased
   assert_clr_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_clr_o |-> (clr_way_q != WW'(WAYS - 1)));
   // R7: done lasts exactly one cycle
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: tb/tb_tlb_dup_scrubber.sv
module tb_tlb_dup_scrubber;
   localparam int SETS = 8, WAYS = 4, PD_W = 32, OFF_W = 13, VLD_BIT = 10, CNT_W = 4;
   localparam int N = SETS * WAYS;
   localparam int AW = $clog2(N), SW = $clog2(SETS), WW = $clog2(WAYS);
   localparam logic [31:0] V = 32'(1) << VLD_BIT;

   logic clk, rst_n, start;
   logic mem_rd, mem_clr, done;
   logic [AW-1:0] addr;
   logic [PD_W-1:0] rdata;
   logic [CNT_W-1:0] cnt;
   logic [SW-1:0] lset;
   logic [WW-1:0] lway;

   tlb_dup_scrubber #(.SETS(SETS), .WAYS(WAYS), .PD_W(PD_W), .OFF_W(OFF_W),
                      .VLD_BIT(VLD_BIT), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mem_rd_o(mem_rd), .mem_clr_o(mem_clr),
      .mem_addr_o(addr), .mem_rdata_i(rdata), .done_o(done), .dup_cnt_o(cnt),
      .last_set_o(lset), .last_way_o(lway));

   initial clk = 1'b0;
   always #4 clk = ~clk;

   logic [31:0] mem [N];
   logic [31:0] exp_mem [N];
   always @(posedge clk) begin
      if (mem_rd) rdata <= mem[addr];
      if (mem_clr) mem[addr] <= '0;
   end

   int checks = 0, errors = 0;
   int exp_q[$];
   int exp_rd, done_seen;
   int got_cnt, got_set, got_way;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor: pops expected clears and tracks the read sequence
   always @(negedge clk) begin
      int e;
      if (rst_n) begin
         if (mem_rd && mem_clr) chk("R10", "read and clear together", 1, 0);
         if (mem_rd) begin
            chk("R2", "read index", int'(addr), exp_rd);
            exp_rd++;
         end
         if (mem_clr) begin
            if (exp_q.size() == 0) chk("R4", "unexpected clear index", int'(addr), -1);
            else begin
               e = exp_q.pop_front();
               chk("R4", "clear index", int'(addr), e);
            end
         end
         if (done) begin
            done_seen++;
            got_cnt = int'(cnt);
            got_set = int'(lset);
            got_way = int'(lway);
         end
      end
   end

   function automatic logic [31:0] mk(input int page, input int low);
      return (32'(page) << OFF_W) | 32'(low);
   endfunction

   // reference model of one scan: fills exp_q and exp_mem
   task automatic build_expect(output int n, output int es, output int ew);
      logic [31:0] loc [WAYS];
      bit anyv;
      n = 0; es = 0; ew = 0;
      exp_q.delete();
      for (int k = 0; k < N; k++) exp_mem[k] = mem[k];
      for (int s = 0; s < SETS; s++) begin
         anyv = 0;
         for (int w = 0; w < WAYS; w++) begin
            loc[w] = mem[s*WAYS+w];
            anyv |= loc[w][VLD_BIT];
         end
         if (anyv) begin
            for (int i = 0; i < WAYS-1; i++) begin
               for (int j = i+1; j < WAYS; j++) begin
                  if (loc[i] != 0 && (loc[i] >> OFF_W) == (loc[j] >> OFF_W)) begin
                     exp_q.push_back(s*WAYS+i);
                     exp_mem[s*WAYS+i] = '0;
                     loc[i] = '0;
                     n++; es = s; ew = i;
                  end
               end
            end
         end
      end
   endtask

   task automatic run_scan(input string tag, input bit second_start);
      int n, es, ew, t, bad, cmax;
      build_expect(n, es, ew);
      cmax = (1 << CNT_W) - 1;
      exp_rd = 0; done_seen = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      if (second_start) begin
         repeat (5) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      t = 0;
      while (done_seen == 0 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      if (done_seen == 0) chk("R7", {tag, " done timeout"}, 0, 1);
      repeat (20) @(negedge clk);
      chk("R9", {tag, " done pulses"}, done_seen, 1);
      chk("R2", {tag, " reads issued"}, exp_rd, N);
      chk("R4", {tag, " clears left pending"}, exp_q.size(), 0);
      chk("R7", {tag, " dup count"}, got_cnt, (n > cmax) ? cmax : n);
      chk("R8", {tag, " last set"}, got_set, es);
      chk("R8", {tag, " last way"}, got_way, ew);
      bad = 0;
      for (int k = 0; k < N; k++) if (mem[k] != exp_mem[k]) bad++;
      chk("R5", {tag, " storage entries differing"}, bad, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0;
      for (int k = 0; k < N; k++) mem[k] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "done after reset", int'(done), 0);
      chk("R1", "count after reset", int'(cnt), 0);
      chk("R1", "read after reset", int'(mem_rd), 0);
      chk("R1", "clear after reset", int'(mem_clr), 0);

      // mixed scenario
      for (int k = 0; k < N; k++) mem[k] = mk(100 + k, k) | V;
      mem[0] = mk(5, 3) | V;  mem[2] = mk(5, 9) | V;             // R4: way0 erased, way2 kept
      for (int k = 4; k < 8; k++) mem[k] = mk(7, k);             // R3: no valid bit
      mem[9] = mk(9, 'h1403); mem[11] = mk(9, 'h001F) | V;       // R6: offsets differ
      mem[12] = mk('h12, 1) | V; mem[13] = mk('h13, 2) | V;      // R6: one page bit differs
      for (int k = 16; k < 20; k++) mem[k] = mk('h20, k) | V;   // R5: cascade of four
      mem[20] = '0;                                              // R5: zero first way
      for (int k = 21; k < 24; k++) mem[k] = mk('h30, k) | V;
      run_scan("mixed", 1'b1);
      chk("R4", "kept higher way of set 0", int'(mem[2] == (mk(5, 9) | V)), 1);
      chk("R3", "invalid set untouched", int'(mem[4] == mk(7, 4)), 1);
      chk("R6", "offset-only difference erased", int'(mem[9]), 0);
      chk("R6", "page bit difference kept", int'(mem[12] == (mk('h12, 1) | V)), 1);

      // saturation scenario: every set fully duplicated
      for (int k = 0; k < N; k++) mem[k] = mk('h77, k) | V;
      run_scan("saturate", 1'b0);

      // clean scenario: no duplicates anywhere
      for (int k = 0; k < N; k++) mem[k] = mk(200 + k, 1) | V;
      run_scan("clean", 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule